// File: doc/BRIEF.md
# DMA Address Window Decoder

This block turns a 32-bit physical address issued by a memory-moving engine into a routing decision. A small bank of programmable windows is held in registers. Each window has a base with an 8-bit target attribute, a 16-bit size mask, and an enable bit plus a 2-bit access field packed into one shared control word. For every lookup the block reports whether the address hit or missed, which window won, that window's target attribute and its access rights.

Software programs the windows through a simple word-indexed register bus. One example layout gives each enabled DRAM chip-select its own window, in packed order, and places one more window after the last DRAM window for on-chip SRAM. DRAM chip-select attributes are one-hot and active-low (0x0E, 0x0D, 0x0B, 0x07 for selects 0 to 3), and SRAM uses 0x1E. A pulse on the save input copies all window registers into a shadow set. A pulse on the restore input copies them back and clears one address-override register per engine.

Top module: `dwm_window_map`

## Requirements
- R1: After a synchronous active-low reset, all windows are disabled. All registers read zero. A lookup returns a miss.
- R2: Registers are addressed by word index: 0 is control, 8+i is the base of window i, 16+i is the mask of window i, and 24+e is the override of engine e. Read data and its valid flag appear one cycle after the read request. Unmapped indices read zero.
- R3: Control bit i enables window i, and control bits [17+2i:16+2i] hold its access field. Only these bits are stored, so with five windows a write of all ones reads back 0x03FF001F.
- R4: The base register keeps bits [31:16] as the window address and bits [15:8] as the target attribute, and reads zero in bits [7:0]. The mask register keeps only bits [31:16].
- R5: An address hits window i when the window is enabled and (addr[31:16] & ~mask) equals (base[31:16] & ~mask). A window therefore spans (mask+1) × 64 KB: with mask 0x0FFF and base 0 it covers up to 0x0FFFFFFF, and with mask 0x03FF and base 0x40000000 it covers up to 0x43FFFFFF.
- R6: A window whose enable bit is clear never hits, whatever its base and mask hold.
- R7: One cycle after a lookup request, the result is valid. It gives the hit flag, the winning window index, that window's attribute and its access field.
- R8: When several windows hit, the lowest-numbered window wins.
- R9: A miss sets the miss flag and clears the hit flag. It reports index 0, attribute 0 and access 0.
- R10: Each engine has a 32-bit override register that reads back exactly what was written.
- R11: A save pulse copies control, bases and masks into a shadow set. A restore pulse copies the shadow set back into the live registers and clears every override register to zero.
- R12: When a restore pulse and a register write arrive in the same cycle, the restore takes precedence and the write is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 6 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after request |
| reg_rvalid | output | 1 | Read data valid |
| snap_save | input | 1 | Copy window registers to shadow set |
| snap_restore | input | 1 | Copy shadow set back, clear overrides |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to decode |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Address hit an enabled window |
| res_miss | output | 1 | Address hit no window |
| res_win | output | 3 | Winning window index |
| res_attr | output | 8 | Target attribute of winner |
| res_access | output | 2 | Access field of winner |

## Verification
Lookup results and read data are each registered once, so both are due one clock edge after the request. Register writes and save or restore pulses take effect at the edge that samples them, so the next lookup or read already sees the new state. The bench changes inputs on the falling edge and reads outputs on the following falling edge. That puts every sample half a cycle clear of the edge that produced it. Each lookup is checked as a whole: valid, hit, miss, index, attribute and access are compared together against values derived from the programmed windows.

// File: rtl/dwm_pkg.sv
// Shared types and register index constants for the address window decoder.
// Assumes at most 8 windows, so enables and access fields fit one word.
package dwm_pkg;

    // Word indices of the register groups on the register bus
    localparam int CTRL_IDX  = 0;
    localparam int BASE_IDX0 = 8;
    localparam int MASK_IDX0 = 16;
    localparam int OVRD_IDX0 = 24;
    localparam int IDX_W     = 6;

    // Bit position where the packed access fields start in the control word
    localparam int ACC_LSB   = 16;

    // Programmed fields of one window
    typedef struct packed {
        logic [15:0] base_hi;
        logic [7:0]  attr;
        logic [15:0] mask;
    } win_cfg_t;

endpackage

// File: rtl/dwm_regs.sv
// Register file of the decoder: live window registers, their shadow copy,
// the per-engine override registers and the registered read path.
// Restore takes precedence over a same-cycle write. Save samples the values
// held before that cycle's write.
module dwm_regs
    import dwm_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int NUM_ENG = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [31:0]                   wdata,
    input  logic                          save,
    input  logic                          restore,
    output logic [31:0]                   rdata,
    output logic                          rvalid,
    output win_cfg_t [NUM_WIN-1:0]        cfg,
    output logic [NUM_WIN-1:0]            en,
    output logic [NUM_WIN-1:0][1:0]       acc
);

    localparam int CTRL_W = ACC_LSB + 2 * NUM_WIN;

    logic                    wr;
    win_cfg_t [NUM_WIN-1:0]  cfg_sv;
    logic [NUM_WIN-1:0]      en_sv;
    logic [NUM_WIN-1:0][1:0] acc_sv;
    logic [NUM_ENG-1:0][31:0] ovrd;
    logic [31:0]             rd_next;

    assign wr = req && we;

    // Control word: enable bits and packed access fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= '0;
            acc <= '0;
        end else if (restore) begin
            en  <= en_sv;
            acc <= acc_sv;
        end else if (wr && idx == IDX_W'(CTRL_IDX)) begin
            en  <= wdata[NUM_WIN-1:0];
            acc <= wdata[CTRL_W-1:ACC_LSB];
        end
    end

    // Shadow copy of the control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_sv  <= '0;
            acc_sv <= '0;
        end else if (save) begin
            en_sv  <= en;
            acc_sv <= acc;
        end
    end

    generate
        for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
            // Live base, attribute and mask of window i
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg[i] <= '0;
                end else if (restore) begin
                    cfg[i] <= cfg_sv[i];
                end else if (wr && idx == IDX_W'(BASE_IDX0 + i)) begin
                    cfg[i].base_hi <= wdata[31:16];
                    cfg[i].attr    <= wdata[15:8];
                end else if (wr && idx == IDX_W'(MASK_IDX0 + i)) begin
                    cfg[i].mask <= wdata[31:16];
                end
            end

            // Shadow copy of window i
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_sv[i] <= '0;
                end else if (save) begin
                    cfg_sv[i] <= cfg[i];
                end
            end
        end

        for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
            // Override register of engine e, cleared on restore
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ovrd[e] <= '0;
                end else if (restore) begin
                    ovrd[e] <= '0;
                end else if (wr && idx == IDX_W'(OVRD_IDX0 + e)) begin
                    ovrd[e] <= wdata;
                end
            end
        end
    endgenerate

    // Read multiplexer over all register groups
    always_comb begin
        rd_next = '0;
        if (idx == IDX_W'(CTRL_IDX)) begin
            rd_next[NUM_WIN-1:0]        = en;
            rd_next[CTRL_W-1:ACC_LSB]   = acc;
        end
        for (int i = 0; i < NUM_WIN; i++) begin
            if (idx == IDX_W'(BASE_IDX0 + i))
                rd_next = {cfg[i].base_hi, cfg[i].attr, 8'h00};
            if (idx == IDX_W'(MASK_IDX0 + i))
                rd_next = {cfg[i].mask, 16'h0000};
        end
        for (int e = 0; e < NUM_ENG; e++) begin
            if (idx == IDX_W'(OVRD_IDX0 + e))
                rd_next = ovrd[e];
        end
    end

    // Registered read data and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= req && !we;
            rdata  <= (req && !we) ? rd_next : '0;
        end
    end

endmodule

// File: rtl/dwm_match.sv
// Per-window comparators: a window hits when it is enabled and the address
// agrees with its base on every upper bit that the mask leaves clear.
// Purely combinational.
module dwm_match
    import dwm_pkg::*;
#(
    parameter int NUM_WIN = 5
) (
    input  logic [15:0]            addr_hi,
    input  win_cfg_t [NUM_WIN-1:0] cfg,
    input  logic [NUM_WIN-1:0]     en,
    output logic [NUM_WIN-1:0]     hit_vec
);

    generate
        for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
            // Masked compare of window i
            assign hit_vec[i] = en[i] &&
                ((addr_hi & ~cfg[i].mask) == (cfg[i].base_hi & ~cfg[i].mask));
        end
    endgenerate

endmodule

// File: rtl/dwm_prio.sv
// Fixed-priority selector: reports whether any window hit and the index of
// the lowest-numbered one. Purely combinational.
module dwm_prio #(
    parameter int NUM_WIN = 5,
    parameter int WIN_W   = 3
) (
    input  logic [NUM_WIN-1:0] hit_vec,
    output logic               any,
    output logic [WIN_W-1:0]   sel
);

    // Scan from the top so the lowest hit is the last assignment
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any = 1'b1;
                sel = WIN_W'(i);
            end
        end
    end

endmodule

// File: rtl/dwm_window_map.sv
// Top of the address window decoder. It registers one lookup result per cycle
// from the window registers held in dwm_regs. Lookups see the register state
// after the previous edge. Assumes 2 to 8 windows.
module dwm_window_map
    import dwm_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int NUM_ENG = 2,
    localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    input  logic              snap_save,
    input  logic              snap_restore,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic [WIN_W-1:0]  res_win,
    output logic [7:0]        res_attr,
    output logic [1:0]        res_access
);

    win_cfg_t [NUM_WIN-1:0]  cfg;
    logic [NUM_WIN-1:0]      en;
    logic [NUM_WIN-1:0][1:0] acc;
    logic [NUM_WIN-1:0]      hit_vec;
    logic                    any;
    logic [WIN_W-1:0]        sel;

    dwm_regs #(.NUM_WIN(NUM_WIN), .NUM_ENG(NUM_ENG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (reg_req),
        .we      (reg_we),
        .idx     (reg_idx),
        .wdata   (reg_wdata),
        .save    (snap_save),
        .restore (snap_restore),
        .rdata   (reg_rdata),
        .rvalid  (reg_rvalid),
        .cfg     (cfg),
        .en      (en),
        .acc     (acc)
    );

    dwm_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr_hi (lk_addr[31:16]),
        .cfg     (cfg),
        .en      (en),
        .hit_vec (hit_vec)
    );

    dwm_prio #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_prio (
        .hit_vec (hit_vec),
        .any     (any),
        .sel     (sel)
    );

    // Result register: winner fields on a hit, all zero on a miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_miss   <= 1'b0;
            res_win    <= '0;
            res_attr   <= '0;
            res_access <= '0;
        end else begin
            res_valid  <= lk_valid;
            res_hit    <= lk_valid && any;
            res_miss   <= lk_valid && !any;
            res_win    <= (lk_valid && any) ? sel : '0;
            res_attr   <= (lk_valid && any) ? cfg[sel].attr : '0;
            res_access <= (lk_valid && any) ? acc[sel] : '0;
        end
    end

endmodule

// File: rtl/dwm_window_map_chk.sv
// Checker for the address window decoder, attached by bind. It watches only
// the top-level ports.
module dwm_window_map_chk #(
    parameter int NUM_WIN = 5,
    parameter int WIN_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_req,
    input logic             reg_we,
    input logic             reg_rvalid,
    input logic             lk_valid,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_miss,
    input logic [WIN_W-1:0] res_win,
    input logic [7:0]       res_attr,
    input logic [1:0]       res_access
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_hit && !reg_rvalid));

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we) |=> reg_rvalid);

    // R7
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R9
    hit_or_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_hit, res_miss}) == 1));

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_attr == 8'h00 && res_access == 2'b00 && res_win == '0));

    // R5
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (int'(res_win) < NUM_WIN));

endmodule

bind dwm_window_map dwm_window_map_chk #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_rvalid (reg_rvalid),
    .lk_valid   (lk_valid),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_miss   (res_miss),
    .res_win    (res_win),
    .res_attr   (res_attr),
    .res_access (res_access)
);

// File: tb/dwm_window_map_test.sv
// Directed bench for the address window decoder. Inputs change on the falling
// edge, and outputs are read on the next falling edge.
module dwm_window_map_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        snap_save = 1'b0;
    logic        snap_restore = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        res_valid, res_hit, res_miss;
    logic [2:0]  res_win;
    logic [7:0]  res_attr;
    logic [1:0]  res_access;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dwm_window_map uut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .snap_save(snap_save), .snap_restore(snap_restore),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
        .res_hit(res_hit), .res_miss(res_miss), .res_win(res_win),
        .res_attr(res_attr), .res_access(res_access)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] data);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_idx = 6'(idx); reg_wdata = data;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [31:0] exp);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b0; reg_idx = 6'(idx);
        @(negedge clk);
        reg_req = 1'b0;
        chk(tag, {reg_rdata[31:1], reg_rdata[0] & reg_rvalid}, exp);
        chk({tag, " rvalid"}, {31'd0, reg_rvalid}, 32'd1);
    endtask

    // Packs valid, hit, miss, index, attribute, access for one compare
    task automatic lk_chk(input string tag, input logic [31:0] addr, input logic hit,
                          input logic [2:0] win, input logic [7:0] attr, input logic [1:0] acc);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = addr;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(tag, {16'd0, res_valid, res_hit, res_miss, res_win, res_attr, res_access},
            {16'd0, 1'b1, hit, !hit, hit ? win : 3'd0, hit ? attr : 8'd0, hit ? acc : 2'd0});
    endtask

    task automatic pulse(input logic sv, input logic rs);
        @(negedge clk);
        snap_save = sv; snap_restore = rs;
        @(negedge clk);
        snap_save = 1'b0; snap_restore = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(input logic [4:0] en, input logic [9:0] acc);
        return {6'd0, acc, 11'd0, en};
    endfunction

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 res_valid after reset", {31'd0, res_valid}, 32'd0);
        rd_chk("R1 control reads zero", 0, 32'd0);
        rd_chk("R1 base0 reads zero", 8, 32'd0);
        lk_chk("R1 lookup misses", 32'h0000_0000, 1'b0, 0, 0, 0);
    endtask

    // R2, R3, R4, R10: readback masking and unmapped index
    task automatic t_readback();
        wr(0, 32'hFFFF_FFFF);
        rd_chk("R3 control stored bits", 0, 32'h03FF_001F);
        wr(12, 32'hFFFF_FFFF);
        rd_chk("R4 base low byte zero", 12, 32'hFFFF_FF00);
        wr(20, 32'hFFFF_FFFF);
        rd_chk("R4 mask low half zero", 20, 32'hFFFF_0000);
        wr(25, 32'hDEAD_BEEF);
        rd_chk("R10 override engine1", 25, 32'hDEAD_BEEF);
        rd_chk("R2 unmapped index zero", 40, 32'd0);
        wr(0, 32'd0);
    endtask

    // R5, R7, R9: DRAM and SRAM windows
    task automatic t_decode();
        wr(8, 32'h0000_0E00);  wr(16, 32'h0FFF_0000);
        wr(9, 32'h1000_0D00);  wr(17, 32'h0FFF_0000);
        wr(10, 32'h4000_1E00); wr(18, 32'h03FF_0000);
        wr(0, ctrl_word(5'b00111, 10'b11_01_11));
        lk_chk("R7 window0 mid", 32'h0800_0000, 1'b1, 0, 8'h0E, 2'b11);
        lk_chk("R5 window0 top byte", 32'h0FFF_FFFF, 1'b1, 0, 8'h0E, 2'b11);
        lk_chk("R7 window1 access01", 32'h1000_0000, 1'b1, 1, 8'h0D, 2'b01);
        lk_chk("R5 sram top byte", 32'h43FF_FFFF, 1'b1, 2, 8'h1E, 2'b11);
        lk_chk("R5 sram size end misses", 32'h4400_0000, 1'b0, 0, 0, 0);
        lk_chk("R9 gap misses", 32'h2000_0000, 1'b0, 0, 0, 0);
    endtask

    // R6, R8: overlapping catch-all window and disable
    task automatic t_overlap();
        wr(11, 32'h0000_0700); wr(19, 32'hFFFF_0000);
        wr(0, ctrl_word(5'b01111, 10'b10_11_01_11));
        lk_chk("R8 catch-all in gap", 32'h2000_0000, 1'b1, 3, 8'h07, 2'b10);
        lk_chk("R8 lowest wins", 32'h0800_0000, 1'b1, 0, 8'h0E, 2'b11);
        wr(0, ctrl_word(5'b01110, 10'b10_11_01_11));
        lk_chk("R6 disabled window0 skipped", 32'h0800_0000, 1'b1, 3, 8'h07, 2'b10);
        wr(0, ctrl_word(5'b00110, 10'b10_11_01_11));
        lk_chk("R6 disabled catch-all misses", 32'h2000_0000, 1'b0, 0, 0, 0);
    endtask

    // R11, R12: save, corrupt, restore
    task automatic t_snapshot();
        wr(0, ctrl_word(5'b00111, 10'b11_01_11));
        pulse(1'b1, 1'b0);
        wr(8, 32'h7000_AA00);
        wr(0, 32'd0);
        wr(24, 32'h1234_5678);
        rd_chk("R10 override engine0", 24, 32'h1234_5678);
        pulse(1'b0, 1'b1);
        rd_chk("R11 base0 restored", 8, 32'h0000_0E00);
        rd_chk("R11 control restored", 0, ctrl_word(5'b00111, 10'b11_01_11));
        rd_chk("R11 override0 cleared", 24, 32'd0);
        rd_chk("R11 override1 cleared", 25, 32'd0);
        lk_chk("R11 lookup after restore", 32'h1000_0000, 1'b1, 1, 8'h0D, 2'b01);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_idx = 6'd9; reg_wdata = 32'h5555_5500;
        snap_restore = 1'b1;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0; snap_restore = 1'b0;
        rd_chk("R12 restore beats write", 9, 32'h1000_0D00);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_decode();
        t_overlap();
        t_snapshot();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule